// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One down-counting channel of an interval timer. A host writes a mode word
(counting mode plus a BCD flag) and then a count. The channel then advances
once per cycle in which the counter-clock enable is high. A single output
traces a mode-dependent waveform: a level that rises at terminal count, a
triggered one-shot, a rate pulse, a square wave, or a one-clock strobe. A gate
input either pauses counting or, in the retriggerable modes, restarts it on a
rising edge. A live count value is offered for reads. Host decoding, read
latching and BCD arithmetic live outside the block. The BCD flag is only
stored and reflected.

The control state machine has six states:

- `ST_IDLE` is entered on reset and on any mode write. The output is held low.
- A count load or gate restart moves it to `ST_ARMED` in modes 0, 1, 4 and 5, and to `ST_CYC_FIRST` in modes 2 and 3.
- `ST_ARMED` moves to `ST_TERM` on the tick that reaches the count. On the next tick `ST_TERM` moves to `ST_DONE`, which then holds.
- `ST_CYC_FIRST` moves to `ST_CYC` on the first period wrap. `ST_CYC` then holds.

In every state, a load or a restart returns the machine to the start state of the mode, and a mode write returns it to `ST_IDLE`. In this text, "elapsed ticks" (d) means the number of enabled counting cycles since the last load or restart, and N means the programmed count.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 0, `count_o` is 0 and `bcd_flag` is 0. After any mode write, `out` stays 0 until a count is loaded.
- R2: A loaded value of 0 acts as N = 2^CNT_W counts.
- R3: In mode 0, `out` is 0 after a load and becomes 1 once d >= N. It stays 1 until the next load or mode write. `count_o` is (N - d) mod 2^CNT_W.
- R4: In mode 1, `out` is 1 exactly when d >= N. `count_o` is (N - d) mod 2^CNT_W. A low gate level does not pause counting.
- R5: In mode 2, `out` is 1 when d is a nonzero multiple of N. `count_o` is N - (d mod N).
- R6: In mode 3, `out` is 1 while (d mod N) < (N+1)/2. `count_o` is N - ((2d) mod N).
- R7: In modes 4 and 5, `out` is 1 only while d == N, which lasts one counter tick. `count_o` is (N - d) mod 2^CNT_W.
- R8: In modes 0 and 4, counting advances only while `gate` is 1. A gate edge never reloads the count.
- R9: In modes 1, 2, 3 and 5, a rising edge on `gate` sets d back to 0.
- R10: A count load sets d to 0 on the load edge, so `count_o` equals the loaded value in the next cycle. A load has priority over a gate restart and a tick. A mode write has priority over a load.
- R11: `mode_sel` codes 0 to 5 select modes 0 to 5. Code 6 acts as mode 2 and code 7 acts as mode 3.
- R12: `bcd_in` is stored on a mode write and shown on `bcd_flag`. It has no effect on counting or on `out`.
- R13: A cycle with `cnt_en` low does not change d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter-clock enable; one tick per high cycle |
| gate | input | 1 | Gate level; pauses or retriggers depending on mode |
| mode_we | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode code |
| bcd_in | input | 1 | BCD flag written with the mode |
| load_we | input | 1 | Count load strobe |
| load_val | input | CNT_W | Count value; 0 means 2^CNT_W |
| out | output | 1 | Channel output waveform |
| count_o | output | CNT_W | Live count |
| bcd_flag | output | 1 | Stored BCD flag |

## Verification
The bench builds the channel with CNT_W = 4. This makes every count from 1 to 16 cheap to reach, including the zero-means-16 case and the wrap of the one-shot count past zero. It sweeps all eight mode codes against all sixteen load values. Each combination runs twice: once with the gate held high, and once with a gate that drops and rises periodically. The counter enable skips every fourth cycle throughout. A reference model computes `out` and `count_o` from d and N in every cycle. Directed runs add a reload in the middle of a count and a long stretch with the enable low.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    typedef enum logic [2:0] {
        M_TC_LEVEL  = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } mode_t;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ARMED     = 3'd1,
        ST_TERM      = 3'd2,
        ST_DONE      = 3'd3,
        ST_CYC_FIRST = 3'd4,
        ST_CYC       = 3'd5
    } state_t;

    function automatic mode_t decode_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11)
            return mode_t'({1'b0, code[1:0]});
        return mode_t'(code);
    endfunction

    function automatic logic gate_retriggers(input mode_t m);
        return (m == M_ONESHOT) || (m == M_RATE) ||
               (m == M_SQUARE)  || (m == M_HW_STROBE);
    endfunction

    function automatic logic is_periodic(input mode_t m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

endpackage

// File: rtl/pit_cfg_regs.sv
`timescale 1ns/1ps
module pit_cfg_regs
    import pit_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NW = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             mode_we,
    input  logic [2:0]       mode_sel,
    input  logic             bcd_in,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             idle,
    output mode_t            mode_q,
    output logic [NW-1:0]    n_q,
    output logic             bcd_q,
    output logic             load_go,
    output logic             restart,
    output logic             tick
);

    localparam logic [NW-1:0] FULL_COUNT = {1'b1, {CNT_W{1'b0}}};

    logic gate_q;
    logic gate_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_TC_LEVEL;
            bcd_q  <= 1'b0;
            n_q    <= FULL_COUNT;
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (mode_we) begin
                mode_q <= decode_mode(mode_sel);
                bcd_q  <= bcd_in;
            end else if (load_we) begin
                n_q <= (load_val == '0) ? FULL_COUNT : {1'b0, load_val};
            end
        end
    end

    always_comb begin
        gate_rise = gate & ~gate_q;
        load_go   = load_we & ~mode_we;
        restart   = ~mode_we & ~load_we & ~idle & gate_rise & gate_retriggers(mode_q);
        tick      = ~mode_we & ~load_we & ~restart & ~idle & cnt_en &
                    (gate | gate_retriggers(mode_q));
    end

endmodule

// File: rtl/pit_ctrl_fsm.sv
`timescale 1ns/1ps
module pit_ctrl_fsm
    import pit_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_we,
    input  logic   load_go,
    input  logic   restart,
    input  logic   tick,
    input  logic   wrap,
    input  mode_t  mode_q,
    output state_t state
);

    state_t state_nx;
    state_t start_state;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        start_state = is_periodic(mode_q) ? ST_CYC_FIRST : ST_ARMED;
        state_nx    = state;
        if (mode_we) begin
            state_nx = ST_IDLE;
        end else if (load_go || restart) begin
            state_nx = start_state;
        end else if (tick) begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ARMED:     state_nx = wrap ? ST_TERM : ST_ARMED;
                ST_TERM:      state_nx = ST_DONE;
                ST_DONE:      state_nx = ST_DONE;
                ST_CYC_FIRST: state_nx = wrap ? ST_CYC : ST_CYC_FIRST;
                ST_CYC:       state_nx = ST_CYC;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pit_phase_ctr.sv
`timescale 1ns/1ps
module pit_phase_ctr #(
    parameter int CNT_W = 16,
    localparam int NW = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_go,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    input  logic [NW-1:0]    n_q,
    output logic [NW-1:0]    phase,
    output logic [CNT_W-1:0] cnt_vis,
    output logic             wrap
);

    logic [NW-1:0] phase_inc;

    always_comb begin
        phase_inc = phase + NW'(1);
        wrap      = (phase_inc == n_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            cnt_vis <= '0;
        end else if (load_go) begin
            phase   <= '0;
            cnt_vis <= load_val;
        end else if (restart) begin
            phase   <= '0;
            cnt_vis <= n_q[CNT_W-1:0];
        end else if (tick) begin
            phase   <= wrap ? '0 : phase_inc;
            cnt_vis <= cnt_vis - CNT_W'(1);
        end
    end

endmodule

// File: rtl/pit_out_decode.sv
`timescale 1ns/1ps
module pit_out_decode
    import pit_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NW = CNT_W + 1
) (
    input  state_t           state,
    input  mode_t            mode_q,
    input  logic [NW-1:0]    phase,
    input  logic [NW-1:0]    n_q,
    input  logic [CNT_W-1:0] cnt_vis,
    output logic             out,
    output logic [CNT_W-1:0] count_o
);

    logic [NW:0]   n_ext;
    logic [NW:0]   half;
    logic [NW:0]   dbl;
    logic [NW:0]   dbl_mod;
    logic [NW-1:0] rate_left;
    logic [NW:0]   sq_left;

    always_comb begin
        n_ext     = {1'b0, n_q};
        half      = (n_ext + (NW+1)'(1)) >> 1;
        dbl       = {phase, 1'b0};
        dbl_mod   = (dbl >= n_ext) ? (dbl - n_ext) : dbl;
        rate_left = n_q - phase;
        sq_left   = n_ext - dbl_mod;
    end

    always_comb begin
        out     = 1'b0;
        count_o = cnt_vis;
        if (state != ST_IDLE) begin
            unique case (mode_q)
                M_TC_LEVEL, M_ONESHOT: begin
                    out = (state == ST_TERM) || (state == ST_DONE);
                end
                M_RATE: begin
                    out     = (state == ST_CYC) && (phase == '0);
                    count_o = rate_left[CNT_W-1:0];
                end
                M_SQUARE: begin
                    out     = ({1'b0, phase} < half);
                    count_o = sq_left[CNT_W-1:0];
                end
                M_SW_STROBE, M_HW_STROBE: begin
                    out = (state == ST_TERM);
                end
                default: out = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             mode_we,
    input  logic [2:0]       mode_sel,
    input  logic             bcd_in,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    output logic             out,
    output logic [CNT_W-1:0] count_o,
    output logic             bcd_flag
);

    localparam int NW = CNT_W + 1;

    mode_t            mode_q;
    state_t           state;
    logic [NW-1:0]    n_q;
    logic [NW-1:0]    phase;
    logic [CNT_W-1:0] cnt_vis;
    logic             load_go;
    logic             restart;
    logic             tick;
    logic             wrap;
    logic             idle;

    assign idle = (state == ST_IDLE);

    pit_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .gate     (gate),
        .mode_we  (mode_we),
        .mode_sel (mode_sel),
        .bcd_in   (bcd_in),
        .load_we  (load_we),
        .load_val (load_val),
        .idle     (idle),
        .mode_q   (mode_q),
        .n_q      (n_q),
        .bcd_q    (bcd_flag),
        .load_go  (load_go),
        .restart  (restart),
        .tick     (tick)
    );

    pit_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_we (mode_we),
        .load_go (load_go),
        .restart (restart),
        .tick    (tick),
        .wrap    (wrap),
        .mode_q  (mode_q),
        .state   (state)
    );

    pit_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_go  (load_go),
        .restart  (restart),
        .tick     (tick),
        .load_val (load_val),
        .n_q      (n_q),
        .phase    (phase),
        .cnt_vis  (cnt_vis),
        .wrap     (wrap)
    );

    pit_out_decode #(.CNT_W(CNT_W)) u_dec (
        .state   (state),
        .mode_q  (mode_q),
        .phase   (phase),
        .n_q     (n_q),
        .cnt_vis (cnt_vis),
        .out     (out),
        .count_o (count_o)
    );

endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate,
    input logic             mode_we,
    input logic [2:0]       mode_sel,
    input logic             load_we,
    input logic [CNT_W-1:0] load_val,
    input logic             out,
    input logic [CNT_W-1:0] count_o,
    input state_t           state,
    input mode_t            mode_q,
    input logic             tick
);

    p_idle_out_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !out);

    p_m0_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_TC_LEVEL && out && !mode_we && !load_we) |=> out);

    p_strobe_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) && out && tick
         && !load_we && !mode_we) |=> !out);

    p_gate_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_TC_LEVEL || mode_q == M_SW_STROBE) && !gate
         && state != ST_IDLE && !load_we && !mode_we) |=> $stable(count_o));

    p_load_shows_n_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !mode_we) |=> (count_o == $past(load_val)));

    p_mode_alias_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_sel[2:1] == 2'b11) |=>
        (mode_q == mode_t'({1'b0, $past(mode_sel[1:0])})));

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (gate),
    .mode_we  (mode_we),
    .mode_sel (mode_sel),
    .load_we  (load_we),
    .load_val (load_val),
    .out      (out),
    .count_o  (count_o),
    .state    (state),
    .mode_q   (mode_q),
    .tick     (tick)
);

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;

    localparam int CW   = 4;
    localparam int MASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0;
    logic          gate = 1'b0;
    logic          mode_we = 1'b0;
    logic [2:0]    mode_sel = 3'd0;
    logic          bcd_in = 1'b0;
    logic          load_we = 1'b0;
    logic [CW-1:0] load_val = '0;
    logic          out;
    logic [CW-1:0] count_o;
    logic          bcd_flag;

    pit_channel #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
        .mode_we(mode_we), .mode_sel(mode_sel), .bcd_in(bcd_in),
        .load_we(load_we), .load_val(load_val),
        .out(out), .count_o(count_o), .bcd_flag(bcd_flag)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    // reference model
    int    m_d = 0;
    int    m_n = 16;
    int    m_md = 0;
    bit    m_prog = 0;
    bit    m_bcd = 0;
    bit    m_gprev = 0;
    bit    fresh = 1;
    string tag_ovr = "";
    int    cur_sel = 0;
    int    cur_val = 0;
    int    cur_pass = 0;

    task automatic compare(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (sel=%0d val=%0d d=%0d)",
                     req, what, act, exp, cur_sel, cur_val, m_d);
        end
    endtask

    function automatic string req_tag();
        if (tag_ovr != "") return tag_ovr;
        if (!m_prog) return "R1";
        if (cur_sel >= 6) return "R11";
        if (cur_val == 0) return "R2";
        if (m_d == 0) return "R10";
        if (cur_pass == 1) return (m_md == 0 || m_md == 4) ? "R8" : "R9";
        case (m_md)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_now();
        int    eo;
        int    ec;
        string t;
        t  = req_tag();
        eo = 0;
        ec = 0;
        if (m_prog) begin
            case (m_md)
                0, 1: begin eo = (m_d >= m_n); ec = (m_n - m_d) & MASK; end
                2: begin eo = ((m_d % m_n) == 0) && (m_d != 0); ec = (m_n - (m_d % m_n)) & MASK; end
                3: begin eo = ((m_d % m_n) < ((m_n + 1) / 2)); ec = (m_n - ((2 * m_d) % m_n)) & MASK; end
                default: begin eo = (m_d == m_n); ec = (m_n - m_d) & MASK; end
            endcase
        end
        compare(t, "out", int'(out), eo);
        if (m_prog || fresh) compare(t, "count", int'(count_o), ec);
        compare("R12", "bcd_flag", int'(bcd_flag), int'(m_bcd));
    endtask

    // one clock: model follows the edge, outputs are checked at the next falling edge
    task automatic cycle();
        bit rtg;
        @(posedge clk);
        rtg = (m_md == 1) || (m_md == 2) || (m_md == 3) || (m_md == 5);
        if (mode_we) begin
            m_md   = (mode_sel >= 6) ? int'(mode_sel) - 4 : int'(mode_sel);
            m_bcd  = bcd_in;
            m_prog = 0;
            fresh  = 0;
        end else if (load_we) begin
            m_n    = (load_val == 0) ? 16 : int'(load_val);
            m_d    = 0;
            m_prog = 1;
        end else if (m_prog && gate && !m_gprev && rtg) begin
            m_d = 0;
        end else if (m_prog && cnt_en && (gate || rtg)) begin
            m_d++;
        end
        m_gprev = gate;
        @(negedge clk);
        check_now();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag_ovr = "R1";
        check_now();
        tag_ovr = "";

        for (int pass = 0; pass < 2; pass++) begin
            for (int sel = 0; sel < 8; sel++) begin
                for (int v = 0; v < 16; v++) begin
                    cur_pass = pass; cur_sel = sel; cur_val = v;
                    mode_we = 1'b1; mode_sel = 3'(sel); bcd_in = v[0];
                    cycle();
                    mode_we = 1'b0;
                    load_we = 1'b1; load_val = CW'(v);
                    cycle();
                    load_we = 1'b0;
                    for (int k = 0; k < 2 * ((v == 0) ? 16 : v) + 5; k++) begin
                        cnt_en = ((k % 4) != 3);   // R13 gaps inside the sweep
                        gate   = (pass == 0) ? 1'b1 : ((k % 6) != 2);
                        cycle();
                    end
                end
            end
        end

        // R10: reload in the middle of a mode 0 count
        tag_ovr = "R10"; cur_sel = 0; cur_val = 9;
        gate = 1'b1; cnt_en = 1'b1;
        mode_we = 1'b1; mode_sel = 3'd0; cycle(); mode_we = 1'b0;
        load_we = 1'b1; load_val = 4'd5; cycle(); load_we = 1'b0;
        repeat (3) cycle();
        load_we = 1'b1; load_val = 4'd9; cycle(); load_we = 1'b0;
        repeat (12) cycle();

        // R13: enable held low freezes a mode 2 count
        tag_ovr = "R13"; cur_sel = 2; cur_val = 3;
        mode_we = 1'b1; mode_sel = 3'd2; cycle(); mode_we = 1'b0;
        load_we = 1'b1; load_val = 4'd3; cycle(); load_we = 1'b0;
        cycle();
        cnt_en = 1'b0;
        repeat (8) cycle();
        cnt_en = 1'b1;
        repeat (4) cycle();

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule